// File: doc/BRIEF.md
# Split-Operand Hybrid Multiplier

This block multiplies two unsigned 8-bit operands and returns the 16-bit product one clock after the operands are applied. It splits each operand into an upper and a lower 4-bit half, which gives four 4×4 partial multiplications. Two of these use a column-compressing tree of full adders, which is fast. The other two use a carry-save array that skips every row whose multiplier bit is zero. In a row that is skipped, no internal value changes.

One half of the first operand is designated the "tree half". The two partial products that involve it go through the tree. The two that involve the other half go through the skipping array, and that other half drives the rows of the array. Wiring the half that usually holds more zeros to the array side therefore saves the most switching. The designated half is fixed at build time by a parameter. The four partial products are weighted by position and summed in one 16-bit adder, and the result is registered.

Top module: `split_hybrid_mul`

## Requirements
- R1: While `rst_n` is low, `prod` is 0.
- R2: `prod` at the clock edge after operands are applied, with reset released, holds the product of the operand values present at that edge (one-cycle latency).
- R3: For all 65536 pairs of `mul_a` and `mul_b`, `prod` equals the full unsigned product `mul_a * mul_b`.
- R4: The upper half of `mul_a` (bits 7:4) times the lower half of `mul_b` (bits 3:0) contributes with a weight of 2^4.
- R5: The upper half of `mul_a` times the upper half of `mul_b` (bits 7:4) contributes with a weight of 2^8.
- R6: The lower half of `mul_a` times the upper half of `mul_b` contributes with a weight of 2^4.
- R7: The lower half of `mul_a` times the lower half of `mul_b` contributes with a weight of 2^0.
- R8: When the half that drives the skipping array is zero, every row of that array is bypassed, and the result equals the tree contributions alone.
- R9: The largest operands (0xFF × 0xFF) give 0xFE01 with no wrap of the 16-bit sum.
- R10: The choice of which half of `mul_a` goes to the tree (`TREE_ON_UPPER`) has no effect on `prod`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mul_a | input | 8 | First operand; its halves are split between the tree and the array |
| mul_b | input | 8 | Second operand |
| prod | output | 16 | Registered unsigned product |

## Verification
The bench builds two copies of the block side by side, one with `TREE_ON_UPPER = 1` and one with `TREE_ON_UPPER = 0`. The two copies route opposite halves of `mul_a` to the tree and to the skipping array. Every stimulus is checked against both copies. This covers both tree-width and array-row paths for every operand pair, and it makes the R10 comparison direct. The 8-bit default width keeps an exhaustive sweep of all operand pairs within the run length. Directed patterns that place nonzero bits in only one half of each operand separate the four weighted contributions.

// File: rtl/shm_pkg.sv
package shm_pkg;
    typedef enum logic {
        STYLE_TREE   = 1'b0,
        STYLE_BYPASS = 1'b1
    } mul_style_e;
endpackage

// File: rtl/shm_tree_mul.sv
module shm_tree_mul #(
    parameter int W = 4
) (
    input  logic [W-1:0]   x,
    input  logic [W-1:0]   y,
    output logic [2*W-1:0] p
);
    localparam int PW     = 2 * W;
    localparam int MAXH   = W + 1;
    localparam int LAYERS = W;

    typedef struct packed {
        logic [PW-1:0] row0;
        logic [PW-1:0] row1;
    } rows_t;

    function automatic rows_t reduce(input logic [W-1:0] fx, input logic [W-1:0] fy);
        logic bits  [PW][MAXH];
        logic nbits [PW][MAXH];
        int   hgt   [PW];
        int   nhgt  [PW];
        rows_t r;
        for (int c = 0; c < PW; c++) begin
            hgt[c] = 0;
            for (int k = 0; k < MAXH; k++) bits[c][k] = 1'b0;
        end
        for (int i = 0; i < W; i++) begin
            for (int j = 0; j < W; j++) begin
                if (hgt[i+j] < MAXH) begin
                    bits[i+j][hgt[i+j]] = fx[i] & fy[j];
                    hgt[i+j] = hgt[i+j] + 1;
                end
            end
        end
        for (int l = 0; l < LAYERS; l++) begin
            for (int c = 0; c < PW; c++) begin
                nhgt[c] = 0;
                for (int k = 0; k < MAXH; k++) nbits[c][k] = 1'b0;
            end
            for (int c = 0; c < PW; c++) begin
                // groups of three equal-weight wires go through a full adder
                for (int g = 0; g < (MAXH / 3) + 1; g++) begin
                    if (3 * g + 2 < hgt[c]) begin
                        if (nhgt[c] < MAXH) begin
                            nbits[c][nhgt[c]] = bits[c][3*g] ^ bits[c][3*g+1] ^ bits[c][3*g+2];
                            nhgt[c] = nhgt[c] + 1;
                        end
                        if (c + 1 < PW && nhgt[c+1] < MAXH) begin
                            nbits[c+1][nhgt[c+1]] = (bits[c][3*g] & bits[c][3*g+1])
                                                  | (bits[c][3*g] & bits[c][3*g+2])
                                                  | (bits[c][3*g+1] & bits[c][3*g+2]);
                            nhgt[c+1] = nhgt[c+1] + 1;
                        end
                    end
                end
                // leftover wires pass on unchanged
                for (int k = 0; k < MAXH; k++) begin
                    if (k >= 3 * (hgt[c] / 3) && k < hgt[c] && nhgt[c] < MAXH) begin
                        nbits[c][nhgt[c]] = bits[c][k];
                        nhgt[c] = nhgt[c] + 1;
                    end
                end
            end
            for (int c = 0; c < PW; c++) begin
                hgt[c] = nhgt[c];
                for (int k = 0; k < MAXH; k++) bits[c][k] = nbits[c][k];
            end
        end
        for (int c = 0; c < PW; c++) begin
            r.row0[c] = (hgt[c] > 0) ? bits[c][0] : 1'b0;
            r.row1[c] = (hgt[c] > 1) ? bits[c][1] : 1'b0;
        end
        return r;
    endfunction

    rows_t rows;

    always_comb begin
        rows = reduce(x, y);
        p    = rows.row0 + rows.row1;
    end

    always_comb begin
        if (!$isunknown({x, y})) begin
            p_tree_exact_r3: assert (p == ({{W{1'b0}}, x} * {{W{1'b0}}, y}))
                else $error("tree sub-product wrong");
        end
    end
endmodule

// File: rtl/shm_bypass_mul.sv
module shm_bypass_mul #(
    parameter int W = 4
) (
    input  logic [W-1:0]   x,
    input  logic [W-1:0]   y,   // row selector: zero bits skip their row
    output logic [2*W-1:0] p
);
    localparam int PW = 2 * W;

    typedef struct packed {
        logic [PW-1:0] sum;
        logic [PW-1:0] cry;
    } cs_t;

    cs_t cs_rows [W+1];

    always_comb begin
        cs_rows[0].sum = '0;
        cs_rows[0].cry = '0;
    end

    for (genvar j = 0; j < W; j++) begin : g_row
        logic [PW-1:0] pp;
        always_comb begin
            pp = {{W{1'b0}}, x} << j;
            if (y[j]) begin
                cs_rows[j+1].sum = cs_rows[j].sum ^ cs_rows[j].cry ^ pp;
                cs_rows[j+1].cry = ((cs_rows[j].sum & cs_rows[j].cry)
                                  | (cs_rows[j].sum & pp)
                                  | (cs_rows[j].cry & pp)) << 1;
            end else begin
                cs_rows[j+1] = cs_rows[j];   // row held: no internal toggling
            end
        end
    end

    always_comb p = cs_rows[W].sum + cs_rows[W].cry;

    always_comb begin
        if (!$isunknown({x, y})) begin
            p_bypass_idle_r8: assert (!(y == '0) || p == '0)
                else $error("bypassed array produced nonzero");
            p_bypass_exact_r3: assert (p == ({{W{1'b0}}, x} * {{W{1'b0}}, y}))
                else $error("array sub-product wrong");
        end
    end
endmodule

// File: rtl/shm_sub_mul.sv
module shm_sub_mul
    import shm_pkg::*;
#(
    parameter int         W     = 4,
    parameter mul_style_e STYLE = STYLE_TREE
) (
    input  logic [W-1:0]   sel_half,
    input  logic [W-1:0]   other_half,
    output logic [2*W-1:0] p
);
    if (STYLE == STYLE_TREE) begin : g_tree
        shm_tree_mul #(.W(W)) u_tree (.x(other_half), .y(sel_half), .p(p));
    end else begin : g_bypass
        shm_bypass_mul #(.W(W)) u_byp (.x(other_half), .y(sel_half), .p(p));
    end
endmodule

// File: rtl/shm_merge.sv
module shm_merge #(
    parameter int W = 4
) (
    input  logic [2*W-1:0] lo_lo,
    input  logic [2*W-1:0] hi_lo,
    input  logic [2*W-1:0] lo_hi,
    input  logic [2*W-1:0] hi_hi,
    output logic [4*W-1:0] total
);
    localparam int RW = 4 * W;

    logic [RW-1:0] t_ll, t_cross, t_hh;

    always_comb begin
        t_ll    = {{(2*W){1'b0}}, lo_lo};
        t_cross = ({{(2*W){1'b0}}, hi_lo} + {{(2*W){1'b0}}, lo_hi}) << W;
        t_hh    = {hi_hi, {(2*W){1'b0}}};
        total   = t_ll + t_cross + t_hh;
    end

    always_comb begin
        if (!$isunknown({lo_lo, hi_lo, lo_hi, hi_hi})) begin
            p_no_overflow_r9: assert (total >= {hi_hi, {(2*W){1'b0}}})
                else $error("weighted sum wrapped");
        end
    end
endmodule

// File: rtl/split_hybrid_mul.sv
module split_hybrid_mul
    import shm_pkg::*;
#(
    parameter int OP_W          = 8,
    parameter bit TREE_ON_UPPER = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   mul_a,
    input  logic [OP_W-1:0]   mul_b,
    output logic [2*OP_W-1:0] prod
);
    localparam int HW = OP_W / 2;
    localparam int PW = 2 * OP_W;
    localparam mul_style_e UP_STYLE = TREE_ON_UPPER ? STYLE_TREE : STYLE_BYPASS;
    localparam mul_style_e LO_STYLE = TREE_ON_UPPER ? STYLE_BYPASS : STYLE_TREE;

    typedef struct packed {
        logic [PW-1:0] prod;
        logic          live;
    } state_t;

    logic [HW-1:0] a_up, a_lo, b_up, b_lo;
    logic [OP_W-1:0] sp_uu, sp_ul, sp_lu, sp_ll;
    logic [PW-1:0] sum_w;
    state_t st_d, st_q;

    assign a_up = mul_a[OP_W-1:HW];
    assign a_lo = mul_a[HW-1:0];
    assign b_up = mul_b[OP_W-1:HW];
    assign b_lo = mul_b[HW-1:0];

    // products sharing an operand-a half share one style
    shm_sub_mul #(.W(HW), .STYLE(UP_STYLE)) u_uu (.sel_half(a_up), .other_half(b_up), .p(sp_uu));
    shm_sub_mul #(.W(HW), .STYLE(UP_STYLE)) u_ul (.sel_half(a_up), .other_half(b_lo), .p(sp_ul));
    shm_sub_mul #(.W(HW), .STYLE(LO_STYLE)) u_lu (.sel_half(a_lo), .other_half(b_up), .p(sp_lu));
    shm_sub_mul #(.W(HW), .STYLE(LO_STYLE)) u_ll (.sel_half(a_lo), .other_half(b_lo), .p(sp_ll));

    shm_merge #(.W(HW)) u_merge (
        .lo_lo(sp_ll), .hi_lo(sp_ul), .lo_hi(sp_lu), .hi_hi(sp_uu), .total(sum_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.prod = sum_w;
        st_d.live = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign prod = st_q.prod;

    p_reset_zero_r1: assert property (@(posedge clk) !rst_n |-> prod == '0)
        else $error("product not cleared in reset");

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.live |-> prod == ({{OP_W{1'b0}}, $past(mul_a)} * {{OP_W{1'b0}}, $past(mul_b)}))
        else $error("registered product mismatch");
endmodule

// File: tb/test_split_hybrid_mul.sv
module test_split_hybrid_mul;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  mul_a = '0;
    logic [7:0]  mul_b = '0;
    logic [15:0] prod, prod_alt;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [7:0]  a;
        logic [7:0]  b;
        logic [15:0] exp;
        string       req;
    } item_t;
    item_t sb_q[$];

    always #4 clk = ~clk;   // 125 MHz

    split_hybrid_mul #(.OP_W(8), .TREE_ON_UPPER(1'b1)) i_split_hybrid_mul (
        .clk(clk), .rst_n(rst_n), .mul_a(mul_a), .mul_b(mul_b), .prod(prod));
    split_hybrid_mul #(.OP_W(8), .TREE_ON_UPPER(1'b0)) i_split_hybrid_mul_alt (
        .clk(clk), .rst_n(rst_n), .mul_a(mul_a), .mul_b(mul_b), .prod(prod_alt));

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s a=%02h b=%02h actual=%04h expected=%04h", req, mul_a, mul_b, act, exp);
        end
    endtask

    task automatic drive(input logic [7:0] a, input logic [7:0] b, input string req);
        item_t it;
        @(negedge clk);
        mul_a = a;
        mul_b = b;
        it.a = a; it.b = b; it.req = req;
        it.exp = {8'h00, a} * {8'h00, b};
        sb_q.push_back(it);
    endtask

    // monitor: each item pushed before an edge is compared just after it
    always @(posedge clk) begin
        #1;
        if (rst_n && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            check(it.req, prod, it.exp);
            check({it.req, " R10 alt"}, prod_alt, it.exp);
            check("R10 both builds agree", prod_alt, prod);
        end
    end

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        mul_a = 8'hA5; mul_b = 8'h3C;
        repeat (3) @(negedge clk);
        check("R1 reset", prod, 16'h0000);
        check("R1 reset alt", prod_alt, 16'h0000);
        rst_n = 1'b1;
        drive(8'h07, 8'h09, "R2 latency");
        drive(8'h00, 8'h00, "R2 zero");
        drive(8'h50, 8'h03, "R4 upper-a x lower-b");
        drive(8'hF0, 8'h0F, "R4 upper-a x lower-b max");
        drive(8'h90, 8'hB0, "R5 upper x upper");
        drive(8'h0D, 8'h60, "R6 lower-a x upper-b");
        drive(8'h0E, 8'h0B, "R7 lower x lower");
        drive(8'hC0, 8'hE7, "R8 lower-a zero");
        drive(8'h0B, 8'h5A, "R8 upper-a zero");
        drive(8'hFF, 8'h00, "R8 b zero");
        drive(8'hFF, 8'hFF, "R9 max");
        drive(8'h80, 8'h80, "R9 top bits");
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                drive(a[7:0], b[7:0], "R3 sweep");
            end
        end
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        if (sb_q.size() != 0) begin
            n_checks++;
            n_fail++;
            $display("FAIL R2 scoreboard left %0d items, expected 0", sb_q.size());
        end
        finish_run();
    end
endmodule